// File: doc/BRIEF.md
# Hierarchical Leading Zero Detector

This block counts the zero bits that come before the first one bit of a 16-bit word, reading from the most significant end. It also raises a flag when the word holds no one bit at all. Typical users are normalisation logic and priority selection. Both need the position of the leading one in as few gate levels as possible.

The word is split into four 4-bit groups. Group 0 holds bits 15..12 and group 3 holds bits 3..0. Each group works out, in parallel with the others, whether it holds any one bit and how many zeros precede its own leading one. A second stage finds the most significant group that holds a one bit, in the same prefix style that carry-lookahead addition uses. That stage needs no wide priority chain across all sixteen bits. It then places the group index in the upper two bits of the count and that group's local count in the lower two bits. A parameter puts an output register behind the logic. That register has an active-low synchronous reset.

Top module: `lzd_hier`

## Requirements
- R1: When `data_i` is nonzero, `count_o` equals the number of zero bits above its most significant one bit (0 to 15). Bit `15 - count_o` of `data_i` is one, and every bit above it is zero.
- R2: `zero_o` is 1 exactly when all 16 bits of `data_i` are zero.
- R3: When `data_i` is all zero, `count_o` is 0.
- R4: When bit 15 of `data_i` is one, `count_o` is 0 whatever the lower bits hold.
- R5: `count_o[3:2]` is the index of the most significant 4-bit group holding a one bit, where group k covers bits `15-4k` down to `12-4k`. `count_o[1:0]` is the count of zeros above the leading one inside that group.
- R6: Bits below the leading one have no effect on `count_o` or `zero_o`.
- R7: With `REG_OUT = 1`, `count_o` and `zero_o` reflect `data_i` as sampled at the previous rising clock edge, and they hold steady between edges. With `REG_OUT = 0`, they follow `data_i` with no clock.
- R8: With `REG_OUT = 1`, a rising edge with `rst_ni` low sets `count_o` to 0 and `zero_o` to 0. A low `rst_ni` between edges changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low synchronous reset of the output register |
| data_i | input | 16 | Operand word |
| count_o | output | 4 | Leading zero count |
| zero_o | output | 1 | Operand was all zero |

## Verification
The combinational instance has its results due as soon as `data_i` settles. The bench therefore drives each word after a falling edge and reads that instance one nanosecond later, well before the next rising edge. The registered instance has its results due one rising edge after the word is applied. It is read one nanosecond after that edge, and it is also read just before the edge to show that the previous result still holds. Reset is checked in the same way: a low `rst_ni` is seen to change nothing until the next rising edge, and the outputs are cleared just after that edge.

// File: rtl/lzd_hier_pkg.sv
package lzd_hier_pkg;

   // True when v is a positive power of two.
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lzd_grp_enc.sv
// First level: a single group reports whether it holds a one bit and how
// many zeros precede its own leading one.
module lzd_grp_enc #(
   parameter int GROUP_W = 4,
   parameter int LW      = $clog2(GROUP_W)
) (
   input  logic [GROUP_W-1:0] bits_i,
   output logic               valid_o,
   output logic [LW-1:0]      lz_o
);

   always_comb begin
      logic found;
      found = 1'b0;
      lz_o  = '0;
      for (int k = GROUP_W - 1; k >= 0; k--) begin
         if (!found && bits_i[k]) begin
            lz_o  = LW'(GROUP_W - 1 - k);
            found = 1'b1;
         end
      end
   end

   assign valid_o = |bits_i;

endmodule

// File: rtl/lzd_grp_sel.sv
// Second level: a lookahead prefix over the group flags picks the most
// significant group that holds a one bit.
module lzd_grp_sel #(
   parameter int N_GROUPS = 4,
   parameter int LW       = 2,
   parameter int GW       = $clog2(N_GROUPS)
) (
   input  logic [N_GROUPS-1:0]    valid_i,
   input  logic [N_GROUPS*LW-1:0] lz_i,
   output logic [GW+LW-1:0]       cnt_o,
   output logic                   zero_o
);

   logic [N_GROUPS:0]   none_above;
   logic [N_GROUPS-1:0] pick;
   logic [GW-1:0]       grp_idx;
   logic [LW-1:0]       grp_loc;

   assign none_above[0] = 1'b1;

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_prefix
      assign none_above[g+1] = none_above[g] & ~valid_i[g];
      assign pick[g]         = valid_i[g] & none_above[g];
   end

   // AND-OR mux: at most one pick bit is set, none for an all-zero word.
   always_comb begin
      grp_idx = '0;
      grp_loc = '0;
      for (int g = 0; g < N_GROUPS; g++) begin
         grp_idx = grp_idx | ({GW{pick[g]}} & GW'(g));
         grp_loc = grp_loc | ({LW{pick[g]}} & lz_i[g*LW +: LW]);
      end
   end

   assign cnt_o  = {grp_idx, grp_loc};
   assign zero_o = none_above[N_GROUPS];

endmodule

// File: rtl/lzd_out_stage.sv
// Optional output register, selected by REG_OUT.
module lzd_out_stage #(
   parameter int CW      = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] cnt_d,
   input  logic          zero_d,
   output logic [CW-1:0] cnt_q,
   output logic          zero_q
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            cnt_q  <= '0;
            zero_q <= 1'b0;
         end else begin
            cnt_q  <= cnt_d;
            zero_q <= zero_d;
         end
      end
   end else begin : g_comb
      assign cnt_q  = cnt_d;
      assign zero_q = zero_d;
   end

endmodule

// File: rtl/lzd_hier.sv
module lzd_hier #(
   parameter int DATA_W  = 16,
   parameter int GROUP_W = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [DATA_W-1:0]         data_i,
   output logic [$clog2(DATA_W)-1:0] count_o,
   output logic                      zero_o
);

   localparam int N_GROUPS = DATA_W / GROUP_W;
   localparam int LW       = $clog2(GROUP_W);
   localparam int GW       = $clog2(N_GROUPS);
   localparam int CW       = $clog2(DATA_W);

   if (!lzd_hier_pkg::is_pow2(DATA_W) || !lzd_hier_pkg::is_pow2(GROUP_W)) begin : g_bad_pow2
      $error("lzd_hier: DATA_W and GROUP_W must be powers of two");
   end
   if (GROUP_W < 2 || N_GROUPS < 2) begin : g_bad_split
      $error("lzd_hier: need at least two groups of at least two bits");
   end

   logic [N_GROUPS-1:0]    grp_valid;
   logic [N_GROUPS*LW-1:0] grp_lz;
   logic [CW-1:0]          cnt_d;
   logic                   zero_d;

   // Group 0 holds the most significant bits.
   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      lzd_grp_enc #(
         .GROUP_W(GROUP_W),
         .LW     (LW)
      ) enc_i (
         .bits_i (data_i[DATA_W-1-g*GROUP_W -: GROUP_W]),
         .valid_o(grp_valid[g]),
         .lz_o   (grp_lz[g*LW +: LW])
      );
   end

   lzd_grp_sel #(
      .N_GROUPS(N_GROUPS),
      .LW      (LW),
      .GW      (GW)
   ) sel_i (
      .valid_i(grp_valid),
      .lz_i   (grp_lz),
      .cnt_o  (cnt_d),
      .zero_o (zero_d)
   );

   lzd_out_stage #(
      .CW     (CW),
      .REG_OUT(REG_OUT)
   ) out_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_d (cnt_d),
      .zero_d(zero_d),
      .cnt_q (count_o),
      .zero_q(zero_o)
   );

endmodule

// File: rtl/lzd_hier_chk.sv
module lzd_hier_chk #(
   parameter int DATA_W  = 16,
   parameter int GROUP_W = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic [DATA_W-1:0]         data_i,
   input logic [$clog2(DATA_W)-1:0] count_o,
   input logic                      zero_o
);

   localparam int CW = $clog2(DATA_W);
   localparam int LW = $clog2(GROUP_W);

   // ref_d is the word the outputs currently describe; ref_ok marks it valid.
   logic [DATA_W-1:0] ref_d;
   logic              ref_ok;
   logic              primed;

   if (REG_OUT) begin : g_lat1
      logic ok_q   = 1'b0;
      logic prim_q = 1'b0;
      always_ff @(posedge clk_i) begin
         ref_d  <= data_i;
         ok_q   <= rst_ni;
         prim_q <= 1'b1;
      end
      assign ref_ok = ok_q;
      assign primed = prim_q;

      assert_reset_clear_R8: assert property (@(posedge clk_i)
         primed && $past(!rst_ni) |-> (count_o == '0) && !zero_o);
   end else begin : g_lat0
      assign ref_d  = data_i;
      assign ref_ok = 1'b1;
      assign primed = 1'b1;
   end

   assert_zero_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_ok |-> (zero_o == (ref_d == '0)));

   assert_zero_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_ok && zero_o |-> (count_o == '0));

   assert_msb_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_ok && ref_d[DATA_W-1] |-> (count_o == '0));

   assert_lead_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_ok && (ref_d != '0) |->
         ref_d[DATA_W-1-int'(count_o)] && ((ref_d >> (DATA_W - int'(count_o))) == '0));

   assert_group_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_ok && (ref_d != '0) |->
         (ref_d[DATA_W-1-GROUP_W*int'(count_o[CW-1:LW]) -: GROUP_W] != '0));

endmodule

bind lzd_hier lzd_hier_chk #(
   .DATA_W (DATA_W),
   .GROUP_W(GROUP_W),
   .REG_OUT(REG_OUT)
) chk_i (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .data_i (data_i),
   .count_o(count_o),
   .zero_o (zero_o)
);

// File: tb/lzd_hier_tb_top.sv
`timescale 1ns/1ps
module lzd_hier_tb_top;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] data  = 16'h0000;
   logic [3:0]  cnt_r, cnt_c;
   logic        z_r, z_c;
   int          n_chk  = 0;
   int          n_fail = 0;
   bit          done   = 1'b0;

   always #2.5 clk = ~clk;

   lzd_hier #(.DATA_W(16), .GROUP_W(4), .REG_OUT(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .data_i(data), .count_o(cnt_r), .zero_o(z_r));

   lzd_hier #(.DATA_W(16), .GROUP_W(4), .REG_OUT(1'b0)) comb_i (
      .clk_i(clk), .rst_ni(rst_n), .data_i(data), .count_o(cnt_c), .zero_o(z_c));

   // Vector fields: {word[15:0], zero flag, count[3:0]}
   localparam logic [20:0] VEC [14] = '{
      {16'h0000, 1'b1, 4'd0},  {16'h8000, 1'b0, 4'd0},  {16'hFFFF, 1'b0, 4'd0},
      {16'h4000, 1'b0, 4'd1},  {16'h2000, 1'b0, 4'd2},  {16'h1000, 1'b0, 4'd3},
      {16'h0800, 1'b0, 4'd4},  {16'h0100, 1'b0, 4'd7},  {16'h01FF, 1'b0, 4'd7},
      {16'h0010, 1'b0, 4'd11}, {16'h001F, 1'b0, 4'd11}, {16'h0001, 1'b0, 4'd15},
      {16'h0003, 1'b0, 4'd14}, {16'h7FFF, 1'b0, 4'd1}
   };

   // Behavioural reference: {zero, count}
   function automatic logic [4:0] ref_lz(input logic [15:0] d);
      for (int i = 15; i >= 0; i--) begin
         if (d[i]) return {1'b0, 4'(15 - i)};
      end
      return {1'b1, 4'd0};
   endfunction

   task automatic check(input string tag, input logic [15:0] d,
                        input logic [4:0] act, input logic [4:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s data=%h actual={zero %b,count %0d} expected={zero %b,count %0d}",
                  tag, d, act[4], act[3:0], exp[4], exp[3:0]);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      // R8: reset state with a nonzero word present
      data = 16'hFFFF;
      repeat (2) @(posedge clk);
      #1 check("R8 reset state", data, {z_r, cnt_r}, 5'b0_0000);
      @(negedge clk) rst_n = 1'b1;

      // Table: R1 R2 R3 R4 R5 R6
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         data = VEC[i][20:5];
         #1 check("R1/R2/R3/R4/R5/R6 table comb", data, {z_c, cnt_c}, VEC[i][4:0]);
         @(posedge clk);
         #1 check("R1/R2/R3/R4/R5/R6 table reg", data, {z_r, cnt_r}, VEC[i][4:0]);
      end

      // R6: lower bits ignored, both words have the leading one at bit 9
      @(negedge clk) data = 16'h0200;
      #1 check("R6 lone bit", data, {z_c, cnt_c}, {1'b0, 4'd6});
      @(negedge clk) data = 16'h03A5;
      #1 check("R6 noisy tail", data, {z_c, cnt_c}, {1'b0, 4'd6});

      // R7: registered output holds until the next rising edge
      @(negedge clk) data = 16'h8000;
      @(posedge clk);
      @(negedge clk) data = 16'h0001;
      #1 check("R7 hold before edge", data, {z_r, cnt_r}, {1'b0, 4'd0});
      check("R7 comb immediate", data, {z_c, cnt_c}, {1'b0, 4'd15});
      @(posedge clk);
      #1 check("R7 update after edge", data, {z_r, cnt_r}, {1'b0, 4'd15});

      // R8: synchronous clear
      @(negedge clk) rst_n = 1'b0;
      #1 check("R8 no async clear", data, {z_r, cnt_r}, {1'b0, 4'd15});
      @(posedge clk);
      #1 check("R8 clear at edge", data, {z_r, cnt_r}, 5'b0_0000);
      @(negedge clk) rst_n = 1'b1;

      // Exhaustive sweep: R1 R2 R3 R5
      for (int v = 0; v < 65536; v++) begin
         @(negedge clk);
         data = v[15:0];
         #1 check("R1/R2/R3/R5 sweep comb", data, {z_c, cnt_c}, ref_lz(data));
         @(posedge clk);
         #1 check("R1/R2/R3/R5 sweep reg", data, {z_r, cnt_r}, ref_lz(data));
      end

      done = 1'b1;
      finish_run();
   end

endmodule